// File: doc/BRIEF.md
# Charge Safety Timeout Counter

This block bounds the time a battery charger may spend charging. It counts periods of a slow timing oscillator, which arrives as an asynchronous strobe, and raises a sticky flag once the active phase has used up its budget. The precharge phase gets one eighth of the main-charge budget. The main-charge budget is measured from the moment the main phase begins, so time spent in precharge does not count against it.

The charge controller drives the block with four controls. A clear command restarts the count, for example when a recharge begins or when the controller resets the timer on entry to main charge. A halt input freezes the count while charging is suspended, and counting resumes from the held value once halt is released. A phase select tells the block which limit applies. A board strap turns the whole timeout function off. The block does not sequence charge modes and does not drive any status output. It only counts, pauses, clears and flags.

Top module: `chg_safety_timer`

## Requirements
- R1: After reset (rstN low), the count is zero and both preTimeout and mainTimeout are 0.
- R2: tickRaw is synchronised and its rising edge is detected. Each low-to-high transition advances the count by exactly one, however many clock cycles tickRaw stays high.
- R3: With phaseMain = 0 (precharge), preTimeout rises once 2^PRE_EXP ticks have been counted (default 2^19). mainTimeout is never set while phaseMain = 0.
- R4: With phaseMain = 1 (main charge), mainTimeout rises once 2^MAIN_EXP ticks have been counted (default 2^22). Any change of phaseMain restarts the count at zero, so precharge ticks are excluded from the main budget. preTimeout is never newly set while phaseMain = 1.
- R5: While haltReq = 1, ticks are ignored and the count keeps its value. Counting continues from that value after haltReq returns to 0.
- R6: A one-cycle clearReq = 1 zeroes the count and both flags. clearReq takes priority over haltReq.
- R7: While timerOff = 1, neither flag is ever 1 in either phase, and the count is held at zero.
- R8: Once set, a flag stays 1 until clearReq, timerOff or reset. The count saturates at 2^MAIN_EXP and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| tickRaw | input | 1 | Asynchronous timing-oscillator strobe |
| timerOff | input | 1 | Strap: 1 disables all timeouts |
| clearReq | input | 1 | Clear count and flags |
| haltReq | input | 1 | Freeze count (suspend) |
| phaseMain | input | 1 | 0 = precharge limit, 1 = main-charge limit |
| preTimeout | output | 1 | Sticky precharge timeout flag |
| mainTimeout | output | 1 | Sticky main-charge timeout flag |

## Verification
The assertions assume that tickRaw stays low for at least two clock cycles between rising edges, so that the edge detector can see every oscillator period. They also assume that the control inputs change synchronously to clk. The stimulus drives every input on the falling clock edge. Each tick pulse is followed by four low cycles. The high time of the pulses varies from one cycle to ten, which keeps the stimulus inside those assumptions while still exercising long strobes. The limits are shrunk to 2^3 and 2^6 so that both thresholds, and ticks well past saturation, can be swept one tick at a time.

// File: rtl/chg_timer_pkg.sv
package chg_timer_pkg;
  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic clear;       // zero the count
    logic clearFlags;  // drop both timeout flags
    logic step;        // advance the count by one
  } tmrCtl_t;
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import chg_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickRaw,
  input  logic    timerOff,
  input  logic    clearReq,
  input  logic    haltReq,
  input  logic    phaseMain,
  output tmrCtl_t ctl
);
  logic [2:0] tickSync;
  logic       phaseQ;
  logic       tickEdge;
  logic       phaseChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickSync <= '0;
      phaseQ   <= 1'b0;
    end else begin
      tickSync <= {tickSync[1:0], tickRaw};
      phaseQ   <= phaseMain;
    end
  end

  assign tickEdge    = tickSync[1] & ~tickSync[2];
  assign phaseChange = phaseMain ^ phaseQ;

  always_comb begin
    ctl.clearFlags = clearReq | timerOff;
    ctl.clear      = clearReq | timerOff | phaseChange;
    ctl.step       = tickEdge & ~haltReq & ~ctl.clear;
  end
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import chg_timer_pkg::*;
#(
  parameter int PRE_EXP  = 19,
  parameter int MAIN_EXP = 22
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrCtl_t             ctl,
  input  logic                phaseMain,
  output logic [MAIN_EXP:0]   cnt,
  output logic                preTimeout,
  output logic                mainTimeout
);
  localparam int CW = MAIN_EXP + 1;
  localparam logic [CW-1:0] PRE_LIM  = CW'(1) << PRE_EXP;
  localparam logic [CW-1:0] MAIN_LIM = CW'(1) << MAIN_EXP;

  logic atMax;
  assign atMax = (cnt == MAIN_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clear) begin
      cnt <= '0;
    end else if (ctl.step && !atMax) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preTimeout  <= 1'b0;
      mainTimeout <= 1'b0;
    end else if (ctl.clearFlags) begin
      preTimeout  <= 1'b0;
      mainTimeout <= 1'b0;
    end else if (!ctl.clear) begin
      if (!phaseMain && cnt >= PRE_LIM) preTimeout  <= 1'b1;
      if (phaseMain && atMax)           mainTimeout <= 1'b1;
    end
  end
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer
  import chg_timer_pkg::*;
#(
  parameter int PRE_EXP  = 19,
  parameter int MAIN_EXP = 22
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickRaw,
  input  logic timerOff,
  input  logic clearReq,
  input  logic haltReq,
  input  logic phaseMain,
  output logic preTimeout,
  output logic mainTimeout
);
  tmrCtl_t           ctl;
  logic [MAIN_EXP:0] cnt;

  tmr_ctl ctl_i (
    .clk(clk), .rstN(rstN), .tickRaw(tickRaw), .timerOff(timerOff),
    .clearReq(clearReq), .haltReq(haltReq), .phaseMain(phaseMain), .ctl(ctl)
  );

  tmr_dp #(.PRE_EXP(PRE_EXP), .MAIN_EXP(MAIN_EXP)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phaseMain(phaseMain),
    .cnt(cnt), .preTimeout(preTimeout), .mainTimeout(mainTimeout)
  );
endmodule

// File: rtl/chg_safety_timer_chk.sv
module chg_safety_timer_chk
  import chg_timer_pkg::*;
#(
  parameter int MAIN_EXP = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              timerOff,
  input logic              clearReq,
  input logic              haltReq,
  input logic              phaseMain,
  input logic              preTimeout,
  input logic              mainTimeout,
  input tmrCtl_t           ctl,
  input logic [MAIN_EXP:0] cnt
);
  localparam logic [MAIN_EXP:0] MAIN_LIM = (MAIN_EXP+1)'(1) << MAIN_EXP;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= MAIN_LIM);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (preTimeout && !clearReq && !timerOff) |=> preTimeout);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.clear && cnt != MAIN_LIM) |=> cnt == $past(cnt) + 1'b1);

  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && !ctl.clear) |=> $stable(cnt));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (cnt == '0 && !preTimeout && !mainTimeout));

  assert_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    timerOff |=> (!preTimeout && !mainTimeout && cnt == '0));

  assert_pre_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(preTimeout) |-> !$past(phaseMain));

  assert_main_phase_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainTimeout) |-> ($past(phaseMain) && $past(cnt) == MAIN_LIM));
endmodule

bind chg_safety_timer chg_safety_timer_chk #(.MAIN_EXP(MAIN_EXP)) chk_i (
  .clk(clk), .rstN(rstN), .timerOff(timerOff), .clearReq(clearReq),
  .haltReq(haltReq), .phaseMain(phaseMain), .preTimeout(preTimeout),
  .mainTimeout(mainTimeout), .ctl(ctl), .cnt(cnt)
);

// File: tb/chg_safety_timer_tb_top.sv
`timescale 1ns/1ps
module chg_safety_timer_tb_top;
  localparam int PRE_EXP  = 3;
  localparam int MAIN_EXP = 6;
  localparam int PRE_N    = 1 << PRE_EXP;
  localparam int MAIN_N   = 1 << MAIN_EXP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickRaw = 1'b0, timerOff = 1'b0, clearReq = 1'b0, haltReq = 1'b0, phaseMain = 1'b0;
  logic preTimeout, mainTimeout;
  int   nChecks = 0, nFails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  chg_safety_timer #(.PRE_EXP(PRE_EXP), .MAIN_EXP(MAIN_EXP)) dut_i (
    .clk(clk), .rstN(rstN), .tickRaw(tickRaw), .timerOff(timerOff),
    .clearReq(clearReq), .haltReq(haltReq), .phaseMain(phaseMain),
    .preTimeout(preTimeout), .mainTimeout(mainTimeout)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one oscillator period: high for hi cycles, then low long enough to settle
  task automatic tick(input int hi);
    @(negedge clk) tickRaw = 1'b1;
    repeat (hi) @(negedge clk);
    tickRaw = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk) clearReq = 1'b1;
    @(negedge clk) clearReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pre after reset", preTimeout, 1'b0);
    chk("R1 main after reset", mainTimeout, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3: precharge sweep with varied strobe lengths
    for (int n = 1; n <= PRE_N + 4; n++) begin
      tick(1 + (n % 4) * 3);
      chk("R2/R3 pre flag", preTimeout, n >= PRE_N);
      chk("R3 no main in precharge", mainTimeout, 1'b0);
    end
    // R3: precharge may run to full scale without a main flag
    for (int n = 0; n < MAIN_N; n++) tick(1);
    chk("R3 main stays low", mainTimeout, 1'b0);

    pulseClear();
    chk("R6 pre cleared", preTimeout, 1'b0);

    // R4: precharge ticks are excluded once main begins
    for (int n = 0; n < 5; n++) tick(2);
    @(negedge clk) phaseMain = 1'b1;
    repeat (2) @(negedge clk);
    for (int n = 1; n <= 2 * MAIN_N + 10; n++) begin
      tick(1 + (n % 3));
      chk("R4/R8 main flag", mainTimeout, n >= MAIN_N);
      if (n % 16 == 0) chk("R4 no pre in main", preTimeout, 1'b0);
    end

    // R5: halt freezes, then resume
    pulseClear();
    chk("R6 main cleared", mainTimeout, 1'b0);
    for (int n = 0; n < 30; n++) tick(2);
    @(negedge clk) haltReq = 1'b1;
    for (int n = 0; n < 50; n++) tick(2);
    chk("R5 halted no flag", mainTimeout, 1'b0);
    @(negedge clk) haltReq = 1'b0;
    for (int n = 0; n < MAIN_N - 31; n++) tick(2);
    chk("R5 one short after resume", mainTimeout, 1'b0);
    tick(2);
    chk("R5 flag after resume", mainTimeout, 1'b1);

    // R6: clear wins over halt
    @(negedge clk) begin haltReq = 1'b1; clearReq = 1'b1; end
    @(negedge clk) begin haltReq = 1'b0; clearReq = 1'b0; end
    chk("R6 cleared under halt", mainTimeout, 1'b0);
    for (int n = 0; n < MAIN_N - 1; n++) tick(2);
    chk("R6 restart from zero", mainTimeout, 1'b0);
    tick(2);
    chk("R6 full count after clear", mainTimeout, 1'b1);

    // R7: disable strap
    @(negedge clk) timerOff = 1'b1;
    @(negedge clk);
    chk("R7 off drops flag", mainTimeout, 1'b0);
    for (int n = 1; n <= 100; n++) begin
      tick(2);
      if (n % 10 == 0) chk("R7 main off", mainTimeout, 1'b0);
    end
    @(negedge clk) phaseMain = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      tick(2);
      if (n % 5 == 0) chk("R7 pre off", preTimeout, 1'b0);
    end
    @(negedge clk) timerOff = 1'b0;
    for (int n = 0; n < PRE_N - 1; n++) tick(2);
    chk("R7 count held at zero", preTimeout, 1'b0);
    tick(2);
    chk("R7 pre after strap off", preTimeout, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule